// File: doc/BRIEF.md
# Tagged receive FIFO

This block is the receive-side character buffer of an asynchronous serial port. The deserializer pushes each completed character together with three per-character error indications: parity error, framing error and line break. The host pops characters one at a time. Each entry keeps its own flags, so the flags of the character at the head are always visible next to that character. When the next read happens, the flags advance with the data.

The buffer holds `DEPTH` entries, 64 by default. It reports its fill level and the empty and full states. It also keeps a summary flag that is high while any stored entry carries an error. A write that finds the buffer full is dropped, and an overflow flag is raised that stays set. A 2-bit selection picks one of four fill thresholds. The threshold drives a level-following data-ready interrupt and a DMA request with hysteresis. A FIFO clear input empties everything in one cycle.

All outputs except the head entry come straight from registers and change in the cycle after the clock edge that sampled the strobe. The head entry is read from the storage at the registered read pointer.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: Characters leave the buffer in the order they were accepted, and up to `DEPTH` (64) entries can be held; `fill_cnt`, `empty` and `full` reflect the count one cycle after the accepting or reading edge.
- R2: While the buffer is not empty, `head_perr`, `head_ferr` and `head_brk` show the flags stored with the character on `head_char`, before it is read; after a read they show the flags of the next character.
- R3: A write while `full` is high discards the incoming character, leaves the count and the stored characters unchanged, and sets `ovf`, which then stays high until a FIFO clear or reset.
- R4: `trig_sel` selects the threshold: 0 selects 1 entry, 1 selects 16, 2 selects 32 and 3 selects 56. `rx_irq` is high exactly when the count after the last edge is at or above the threshold.
- R5: `dma_req` rises when the count reaches the selected threshold and stays high until the buffer becomes empty.
- R6: `err_any` is high exactly while at least one entry in the buffer has any of its three flags set.
- R7: A `fifo_clr` pulse empties the buffer and clears `ovf`, `err_any`, `rx_irq` and `dma_req` in the next cycle, whatever else is driven in that cycle.
- R8: A read while the buffer is empty is ignored: the count stays 0, `empty` stays high and `ovf` is unaffected.
- R9: A simultaneous read and write on a buffer that is neither empty nor full keeps the count unchanged and appends the new character behind the others.
- R10: The synchronous, active-high `rst` leaves the buffer empty with `full`, `ovf`, `err_any`, `rx_irq` and `dma_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_char | input | CHAR_W | Received character |
| wr_perr | input | 1 | Parity error for this character |
| wr_ferr | input | 1 | Framing error for this character |
| wr_brk | input | 1 | Break condition for this character |
| rd_en | input | 1 | Host pop strobe |
| fifo_clr | input | 1 | Empties the buffer and clears all flags |
| trig_sel | input | 2 | Threshold selection (1/16/32/56 entries) |
| head_char | output | CHAR_W | Character at the head |
| head_perr | output | 1 | Parity flag of the head entry |
| head_ferr | output | 1 | Framing flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| fill_cnt | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |
| ovf | output | 1 | Sticky overflow flag |
| err_any | output | 1 | Some stored entry carries an error flag |
| rx_irq | output | 1 | Data-ready interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its default parameters: 64 entries, 8-bit characters and thresholds 1, 16, 32 and 56. With these values the full state and the highest threshold are reachable within a few hundred cycles. Random stimulus alternates between fill-biased and drain-biased bursts, so the count repeatedly crosses every threshold in both directions, hits full, and drives the `dma_req` hysteresis through both of its edges. Error flags are injected sparsely so that `err_any` toggles as flagged entries enter and leave. Directed runs cover overflow on a full buffer, reading an empty buffer, balanced read/write traffic and clear in the middle of traffic.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int L0    = 1,
  parameter int L1    = 16,
  parameter int L2    = 32,
  parameter int L3    = 56
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [1:0]    trig_sel,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full,
  output logic          irq,
  output logic          dma
);
  logic [CW-1:0] cnt_n, lvl;

  always_comb begin
    unique case (trig_sel)
      2'd0:    lvl = CW'(L0);
      2'd1:    lvl = CW'(L1);
      2'd2:    lvl = CW'(L2);
      default: lvl = CW'(L3);
    endcase
  end

  assign cnt_n = cnt + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
      irq   <= 1'b0;
      dma   <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      empty <= (cnt_n == '0);
      full  <= (cnt_n == CW'(DEPTH));
      irq   <= (cnt_n >= lvl);
      if (cnt_n >= lvl)     dma <= 1'b1;
      else if (cnt_n == '0) dma <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter int CW = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic pop,
  input  logic push_err,
  input  logic pop_err,
  output logic err_any
);
  logic [CW-1:0] n_bad, n_bad_n;

  assign n_bad_n = n_bad + {{(CW-1){1'b0}}, push & push_err}
                         - {{(CW-1){1'b0}}, pop & pop_err};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      n_bad   <= '0;
      err_any <= 1'b0;
    end else begin
      n_bad   <= n_bad_n;
      err_any <= (n_bad_n != '0);
    end
  end
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  parameter int TRIG0  = 1,
  parameter int TRIG1  = 16,
  parameter int TRIG2  = 32,
  parameter int TRIG3  = 56,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              fifo_clr,
  input  logic [1:0]        trig_sel,
  output logic [CHAR_W-1:0] head_char,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic [CW-1:0]     fill_cnt,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              err_any,
  output logic              rx_irq,
  output logic              dma_req
);
  localparam int EW = CHAR_W + FLAG_W;

  rx_flags_t         in_f, hd_f;
  logic [EW-1:0]     in_ent, hd_ent;
  logic              push, pop;

  assign in_f   = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};
  assign in_ent = {in_f, wr_char};
  assign push   = wr_en & ~full;
  assign pop    = rd_en & ~empty;

  rxq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(push), .pop(pop), .din(in_ent), .dout(hd_ent)
  );

  rxq_level #(
    .DEPTH(DEPTH), .CW(CW),
    .L0(TRIG0), .L1(TRIG1), .L2(TRIG2), .L3(TRIG3)
  ) u_level (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(push), .pop(pop), .trig_sel(trig_sel),
    .cnt(fill_cnt), .empty(empty), .full(full),
    .irq(rx_irq), .dma(dma_req)
  );

  assign hd_f      = hd_ent[EW-1:CHAR_W];
  assign head_char = hd_ent[CHAR_W-1:0];
  assign head_perr = hd_f.perr;
  assign head_ferr = hd_f.ferr;
  assign head_brk  = hd_f.brk;

  rxq_errtrack #(.CW(CW)) u_err (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(push), .pop(pop),
    .push_err(|in_f), .pop_err(|hd_f),
    .err_any(err_any)
  );

  always_ff @(posedge clk) begin
    if (rst || fifo_clr) ovf <= 1'b0;
    else if (wr_en && full) ovf <= 1'b1;
  end
endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          fifo_clr,
  input logic [CW-1:0] fill_cnt,
  input logic          empty,
  input logic          full,
  input logic          ovf,
  input logic          err_any,
  input logic          rx_irq,
  input logic          dma_req
);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !fifo_clr) |=> ovf);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !fifo_clr) |=> (fill_cnt == CW'(DEPTH)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf && !fifo_clr) |=> ovf);

  p_irq_data_r4: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !empty);

  p_dma_data_r5: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !empty);

  p_err_data_r6: assert property (@(posedge clk) disable iff (rst)
    err_any |-> !empty);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (empty && !ovf && !err_any && !rx_irq && !dma_req));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !fifo_clr) |=> (empty && fill_cnt == '0));

  p_balanced_r9: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && wr_en && rd_en && !fifo_clr) |=> $stable(fill_cnt));
endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .fifo_clr(fifo_clr),
  .fill_cnt(fill_cnt), .empty(empty), .full(full), .ovf(ovf),
  .err_any(err_any), .rx_irq(rx_irq), .dma_req(dma_req)
);

// File: tb/rxq_tagged_fifo_tb_top.sv
module rxq_tagged_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 0, rd_en = 0, fifo_clr = 0;
  logic [7:0]    wr_char = 0;
  logic          wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic [1:0]    trig_sel = 0;
  logic [7:0]    head_char;
  logic          head_perr, head_ferr, head_brk;
  logic [CW-1:0] fill_cnt;
  logic          empty, full, ovf, err_any, rx_irq, dma_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] mq[$];
  bit m_ovf = 0, m_irq = 0, m_dma = 0;

  always #5 clk = ~clk;

  rxq_tagged_fifo dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rd_en(rd_en), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .head_char(head_char), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .fill_cnt(fill_cnt), .empty(empty), .full(full),
    .ovf(ovf), .err_any(err_any), .rx_irq(rx_irq), .dma_req(dma_req)
  );

  function automatic int lvl_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction

  function automatic bit model_err();
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int n;
    bit wa, ra;
    if (rst || fifo_clr) begin
      mq.delete();
      m_ovf = 0; m_irq = 0; m_dma = 0;
    end else begin
      wa = wr_en && (mq.size() < DEPTH);
      ra = rd_en && (mq.size() > 0);
      if (wr_en && mq.size() == DEPTH) m_ovf = 1;
      if (ra) void'(mq.pop_front());
      if (wa) mq.push_back({wr_brk, wr_ferr, wr_perr, wr_char});
      n = mq.size();
      m_irq = (n >= lvl_of(trig_sel));
      if (n >= lvl_of(trig_sel)) m_dma = 1;
      else if (n == 0) m_dma = 0;
    end
  endtask

  task automatic check_all();
    chk("R1 fill count", fill_cnt, mq.size());
    chk("R1 empty", empty, mq.size() == 0);
    chk("R1 full", full, mq.size() == DEPTH);
    if (mq.size() > 0) begin
      chk("R1 head char", head_char, mq[0][7:0]);
      chk("R2 head flags", {head_brk, head_ferr, head_perr}, mq[0][10:8]);
    end
    chk("R3 overflow", ovf, m_ovf);
    chk("R4 interrupt", rx_irq, m_irq);
    chk("R5 dma request", dma_req, m_dma);
    chk("R6 error summary", err_any, model_err());
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_in(bit w, bit r, bit c, logic [7:0] ch, logic [2:0] fl);
    wr_en = w; rd_en = r; fifo_clr = c; wr_char = ch;
    {wr_brk, wr_ferr, wr_perr} = fl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R10: reset state
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R10 empty after reset", empty, 1);
    chk("R10 full after reset", full, 0);
    chk("R10 count after reset", fill_cnt, 0);
    chk("R10 flags after reset", {ovf, err_any, rx_irq, dma_req}, 0);

    // R8: reading an empty buffer
    set_in(0, 1, 0, 8'h00, 3'b000);
    tick(); tick();
    chk("R8 count after empty read", fill_cnt, 0);
    chk("R8 ovf after empty read", ovf, 0);

    // R1/R3/R4: fill to full at threshold 56, then overflow
    trig_sel = 2'd3;
    for (int i = 0; i < DEPTH; i++) begin
      set_in(1, 0, 0, 8'(i + 8'h40), (i % 7 == 3) ? 3'(i % 8) | 3'b001 : 3'b000);
      tick();
      if (i == 54) chk("R4 irq below 56", rx_irq, 0);
      if (i == 55) chk("R4 irq at 56", rx_irq, 1);
    end
    chk("R1 full at capacity", full, 1);
    for (int i = 0; i < 3; i++) begin
      set_in(1, 0, 0, 8'hEE, 3'b111);
      tick();
    end
    chk("R3 count held at full", fill_cnt, DEPTH);
    chk("R3 overflow set", ovf, 1);
    for (int i = 0; i < DEPTH + 2; i++) begin
      set_in(0, 1, 0, 8'h00, 3'b000);
      tick();
      if (i == 8) chk("R4 irq drops below 56", rx_irq, 0);
      if (i == 8) chk("R5 dma holds until empty", dma_req, 1);
    end
    chk("R5 dma low when empty", dma_req, 0);
    chk("R3 overflow sticky", ovf, 1);

    // R9: balanced traffic
    trig_sel = 2'd1;
    for (int i = 0; i < 5; i++) begin
      set_in(1, 0, 0, 8'(i), 3'b000); tick();
    end
    for (int i = 0; i < 12; i++) begin
      set_in(1, 1, 0, 8'(8'h80 + i), (i == 4) ? 3'b010 : 3'b000); tick();
    end
    chk("R9 count stable", fill_cnt, 5);

    // R7: clear during traffic
    set_in(1, 1, 1, 8'h55, 3'b100);
    tick();
    chk("R7 empty after clear", empty, 1);
    chk("R7 flags after clear", {ovf, err_any, rx_irq, dma_req}, 0);

    // Random bursts, alternating fill and drain bias
    for (int seg = 0; seg < 40; seg++) begin
      int pw, pr;
      trig_sel = 2'($urandom_range(3));
      pw = (seg % 2 == 0) ? 85 : 30;
      pr = (seg % 2 == 0) ? 25 : 80;
      for (int k = 0; k < 150; k++) begin
        logic [2:0] fl;
        fl[0] = ($urandom_range(9) == 0);
        fl[1] = ($urandom_range(11) == 0);
        fl[2] = ($urandom_range(15) == 0);
        set_in($urandom_range(99) < pw, $urandom_range(99) < pr,
               $urandom_range(399) == 0, 8'($urandom), fl);
        tick();
      end
    end

    set_in(0, 0, 0, 8'h00, 3'b000);
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule